// File: doc/BRIEF.md
# Flash Embedded Operation Status Controller

This block is the command and sequencing core of a byte-wide flash memory. It also holds a behavioural model of the array. The host issues bus cycles. Write cycles feed a command decoder that needs a fixed unlock sequence. A completed sequence starts one of three operations: a timed program of one byte, an erase of a chosen set of sectors, or an erase of the whole chip. Read cycles return array bytes when the device is quiet. While an operation is running they return a status byte, so the host can follow progress by polling. The status byte holds a data-polling bit and two toggle bits.

An erase has three steps. First, a sweep programs every byte of the selected sectors to 0x00. Then a timed wait follows. Last, a sweep writes 0xFF to every selected byte. A suspend command freezes the erase at any step. While suspended, the host can read the sectors that are not being erased and can program bytes in them. A resume command then continues the erase from the point where it stopped. The asynchronous reset aborts any operation and leaves the controller in read-array mode. Array contents are not cleared by reset.

The array has `2**AW` bytes and is split into seven sectors. Sector sizes are counted in units of `2**AW/32` bytes. With `AW=17` this gives the full 128 KB map, in which one unit is 4 KB.

Requests use a valid/ready handshake. A request moves on a rising edge where `bus_valid` and `bus_ready` are both high. A read answers on `rsp_valid` in the cycle after it is accepted. The answer holds until `rsp_ready` is high at an edge. While an unconsumed answer is waiting, `bus_ready` is low, so a response is never overwritten.

Top module: `flash_op_ctl`

## Requirements
- R1: Sector sizes, in units, run 2,1,1,4,8,8,8 from address 0 when `BOOT_TOP=0`, and 8,8,8,4,1,1,2 when `BOOT_TOP=1`. The sector index follows the same order.
- R2: Every command begins with two unlock writes: (addr[7:0]=0x55, data 0xAA), then (0xAA, 0x55). The third write goes to 0x55 with the command: 0xA0 means the next write is a program (address and data). 0x80 means erase setup, which is followed by the two unlock writes again and then either 0x10 at 0x55 (chip erase) or 0x30 at any address in the sector to erase. A write that breaks the sequence, or a data value of 0xF0 outside the program data cycle, returns the decoder to its start state, and the write has no effect on the array.
- R3: A program completes `PROG_CYC` cycles after its data write. The byte becomes old AND new, so bits can only be cleared.
- R4: An erase leaves every byte of the selected sectors at 0xFF and leaves other sectors untouched. Each further 0x30 write within `SEL_WIN` cycles of the previous one adds its sector to the set. Chip erase selects all seven sectors.
- R5: In a status byte, bits 5, 4, 3, 1 and 0 are 0.
- R6: Status bit 6 inverts on every status read while an operation is running, and also on status reads of an erasing sector during suspend.
- R7: During an erase, including a suspended one, status bit 2 inverts on reads whose address falls in a selected sector. On other reads bit 2 holds.
- R8: During a program, status bit 7 is the complement of bit 7 of the data being programmed. During an erase it is 0. After completion, reads return true array data.
- R9: A write of 0xB0 suspends an erase. While suspended, reads of unselected sectors return array data and reads of selected sectors return status. A write of 0x30 resumes the erase, and the erase then completes.
- R10: While suspended, a program aimed at an unselected sector runs to completion and returns the controller to the suspended state. A program aimed at a selected sector is ignored.
- R11: Reset aborts a running operation without writing the array. Reads then return array data, and new commands are accepted.
- R12: After reset, `bus_ready` is 1 and `rsp_valid` is 0. A read answers one cycle after acceptance. While `rsp_valid` is high and `rsp_ready` is low, the answer holds and `bus_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; aborts any operation |
| bus_valid | input | 1 | Request valid |
| bus_ready | output | 1 | Request accepted on this edge when high |
| bus_we | input | 1 | 1 for a command write, 0 for a read |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read answer valid |
| rsp_ready | input | 1 | Host takes the read answer |
| rsp_data | output | 8 | Array byte or status byte |

## Verification
The bench programs every byte with an arithmetic pattern and then erases sector pairs that sit on both sides of the small-sector boundaries. A wrong sector map would show up as a stray 0xFF, or as a surviving pattern byte, at a boundary. Reads alternate between selected and unselected sectors during an erase. This catches a bit 2 that toggles everywhere, or a bit 6 that misses a read. A suspend is placed inside the preprogram sweep, and a program in a non-erasing sector runs during it. A design that kept only one timer would lose its place in the erase, and a design that returned status for every address would hide the sector being programmed. A reset in the middle of a program catches a design that commits the partial write, and a read held under back-pressure catches an answer that is overwritten.

// File: rtl/flash_op_pkg.sv
package flash_op_pkg;
  typedef enum logic [2:0] {S_IDLE, S_COLLECT, S_PROG, S_ERASE, S_SUSP, S_SPROG} op_st_e;
  typedef enum logic [1:0] {PH_PRE, PH_WAIT, PH_FILL} ers_ph_e;

  localparam int NSEC = 7;
  localparam int UNIT_BITS = 5;   // 32 units across the address space

  localparam logic [7:0] KEY_A1   = 8'h55;
  localparam logic [7:0] KEY_A2   = 8'hAA;
  localparam logic [7:0] KEY_D1   = 8'hAA;
  localparam logic [7:0] KEY_D2   = 8'h55;
  localparam logic [7:0] OP_PROG  = 8'hA0;
  localparam logic [7:0] OP_SETUP = 8'h80;
  localparam logic [7:0] OP_CHIP  = 8'h10;
  localparam logic [7:0] OP_SECT  = 8'h30;
  localparam logic [7:0] OP_SUSP  = 8'hB0;
  localparam logic [7:0] OP_CLEAR = 8'hF0;
  localparam logic [7:0] STAT_ZERO_MASK = 8'h3B;
endpackage

// File: rtl/fl_sector_map.sv
module fl_sector_map #(
  parameter bit BOOT_TOP = 1'b0
) (
  input  logic [4:0] unit,
  output logic [2:0] sec
);
  generate
    if (BOOT_TOP) begin : g_top
      always_comb begin
        if (unit < 5'd8)        sec = 3'd0;
        else if (unit < 5'd16)  sec = 3'd1;
        else if (unit < 5'd24)  sec = 3'd2;
        else if (unit < 5'd28)  sec = 3'd3;
        else if (unit == 5'd28) sec = 3'd4;
        else if (unit == 5'd29) sec = 3'd5;
        else                    sec = 3'd6;
      end
    end else begin : g_bottom
      always_comb begin
        if (unit < 5'd2)        sec = 3'd0;
        else if (unit == 5'd2)  sec = 3'd1;
        else if (unit == 5'd3)  sec = 3'd2;
        else if (unit < 5'd8)   sec = 3'd3;
        else if (unit < 5'd16)  sec = 3'd4;
        else if (unit < 5'd24)  sec = 3'd5;
        else                    sec = 3'd6;
      end
    end
  endgenerate
endmodule

// File: rtl/fl_cmd_seq.sv
module fl_cmd_seq
  import flash_op_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic       allow,
  input  logic       allow_ers,
  input  logic [7:0] a8,
  input  logic [7:0] d,
  output logic       at_rest,
  output logic       go_prog,
  output logic       go_chip,
  output logic       go_sect
);
  logic [2:0] step_q, step_d;
  logic key1, key2;

  assign key1 = (a8 == KEY_A1) && (d == KEY_D1);
  assign key2 = (a8 == KEY_A2) && (d == KEY_D2);
  assign at_rest = (step_q == 3'd0);

  always_comb begin
    step_d  = step_q;
    go_prog = 1'b0;
    go_chip = 1'b0;
    go_sect = 1'b0;
    if (!allow) begin
      step_d = 3'd0;
    end else if (wr) begin
      if (d == OP_CLEAR && step_q != 3'd3) begin
        step_d = 3'd0;
      end else begin
        case (step_q)
          3'd0: step_d = key1 ? 3'd1 : 3'd0;
          3'd1: step_d = key2 ? 3'd2 : 3'd0;
          3'd2: begin
            if (a8 == KEY_A1 && d == OP_PROG)                    step_d = 3'd3;
            else if (a8 == KEY_A1 && d == OP_SETUP && allow_ers) step_d = 3'd4;
            else                                                 step_d = 3'd0;
          end
          3'd3: begin go_prog = 1'b1; step_d = 3'd0; end
          3'd4: step_d = key1 ? 3'd5 : 3'd0;
          3'd5: step_d = key2 ? 3'd6 : 3'd0;
          3'd6: begin
            if (a8 == KEY_A1 && d == OP_CHIP) go_chip = 1'b1;
            else if (d == OP_SECT)            go_sect = 1'b1;
            step_d = 3'd0;
          end
          default: step_d = 3'd0;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_q <= 3'd0;
    else        step_q <= step_d;
  end

  // R2: a launched command always leaves the decoder back at its start
  p_launch_rest_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (go_prog || go_chip || go_sect) |=> at_rest);
endmodule

// File: rtl/fl_array.sv
module fl_array #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic [AW-1:0] ra,
  output logic [7:0]    rd,
  input  logic          we,
  input  logic          and_mode,
  input  logic [AW-1:0] wa,
  input  logic [7:0]    wd
);
  localparam int DEPTH = 1 << AW;
  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[wa] <= and_mode ? (cells[wa] & wd) : wd;
  end

  assign rd = cells[ra];
endmodule

// File: rtl/flash_op_ctl.sv
module flash_op_ctl
  import flash_op_pkg::*;
#(
  parameter int AW       = 10,
  parameter bit BOOT_TOP = 1'b0,
  parameter int PROG_CYC = 8,
  parameter int ERS_CYC  = 40,
  parameter int SEL_WIN  = 6,
  parameter int CNT_W    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_valid,
  output logic          bus_ready,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [7:0]    bus_wdata,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [7:0]    rsp_data
);
  localparam logic [AW-1:0] LAST = {AW{1'b1}};

  op_st_e          st;
  ers_ph_e         phase;
  logic [AW-1:0]   idx, paddr;
  logic [7:0]      pdata, mem_q, status, m_wd;
  logic [CNT_W-1:0] pcnt, ecnt;
  logic [NSEC-1:0] sel;
  logic            tog6, tog2;
  logic            wr_acc, rd_acc, hit, erase_act, busy, dq7;
  logic [2:0]      sec_bus, sec_idx;
  logic            at_rest, go_prog, go_chip, go_sect;
  logic            m_we, m_and;
  logic [AW-1:0]   m_wa;

  assign bus_ready = !rsp_valid || rsp_ready;
  assign wr_acc = bus_valid && bus_ready && bus_we;
  assign rd_acc = bus_valid && bus_ready && !bus_we;

  fl_sector_map #(.BOOT_TOP(BOOT_TOP)) u_map_bus (
    .unit(bus_addr[AW-1 -: UNIT_BITS]), .sec(sec_bus));
  fl_sector_map #(.BOOT_TOP(BOOT_TOP)) u_map_scan (
    .unit(idx[AW-1 -: UNIT_BITS]), .sec(sec_idx));

  fl_cmd_seq u_seq (
    .clk(clk), .rst_n(rst_n), .wr(wr_acc),
    .allow(st == S_IDLE || st == S_SUSP), .allow_ers(st == S_IDLE),
    .a8(bus_addr[7:0]), .d(bus_wdata), .at_rest(at_rest),
    .go_prog(go_prog), .go_chip(go_chip), .go_sect(go_sect));

  fl_array #(.AW(AW)) u_arr (
    .clk(clk), .ra(bus_addr), .rd(mem_q), .we(m_we), .and_mode(m_and),
    .wa(m_wa), .wd(m_wd));

  assign hit       = sel[sec_bus];
  assign erase_act = (st == S_COLLECT) || (st == S_ERASE) || (st == S_SUSP) || (st == S_SPROG);
  assign busy      = (st == S_COLLECT) || (st == S_ERASE) || (st == S_PROG) ||
                     (st == S_SPROG) || (st == S_SUSP && hit);
  assign dq7       = (st == S_PROG || st == S_SPROG) ? ~pdata[7] : 1'b0;
  assign status    = {dq7, tog6, 3'b000, (erase_act && hit) ? tog2 : 1'b0, 2'b00};

  // array write port: program commit or erase sweeps
  always_comb begin
    m_we  = 1'b0;
    m_and = 1'b0;
    m_wa  = idx;
    m_wd  = 8'h00;
    if ((st == S_PROG || st == S_SPROG) && pcnt == '0) begin
      m_we  = 1'b1;
      m_and = 1'b1;
      m_wa  = paddr;
      m_wd  = pdata;
    end else if (st == S_ERASE && phase != PH_WAIT && sel[sec_idx]) begin
      m_we = 1'b1;
      m_wd = (phase == PH_FILL) ? 8'hFF : 8'h00;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; phase <= PH_PRE; idx <= '0; paddr <= '0; pdata <= '0;
      pcnt <= '0; ecnt <= '0; sel <= '0; tog6 <= 1'b0; tog2 <= 1'b0;
      rsp_valid <= 1'b0; rsp_data <= '0;
    end else begin
      if (rd_acc) begin
        rsp_valid <= 1'b1;
        rsp_data  <= busy ? status : mem_q;
        if (busy) tog6 <= ~tog6;
        if (busy && erase_act && hit) tog2 <= ~tog2;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end

      case (st)
        S_IDLE: begin
          if (go_prog) begin
            st <= S_PROG; paddr <= bus_addr; pdata <= bus_wdata;
            pcnt <= CNT_W'(PROG_CYC - 1);
          end else if (go_chip) begin
            sel <= '1; st <= S_ERASE; phase <= PH_PRE; idx <= '0;
          end else if (go_sect) begin
            sel <= NSEC'(1) << sec_bus; st <= S_COLLECT;
            ecnt <= CNT_W'(SEL_WIN - 1);
          end
        end
        S_COLLECT: begin
          if (wr_acc && bus_wdata == OP_SECT) begin
            sel[sec_bus] <= 1'b1; ecnt <= CNT_W'(SEL_WIN - 1);
          end else if (ecnt == '0) begin
            st <= S_ERASE; phase <= PH_PRE; idx <= '0;
          end else begin
            ecnt <= ecnt - 1'b1;
          end
        end
        S_PROG:  if (pcnt == '0) st <= S_IDLE; else pcnt <= pcnt - 1'b1;
        S_SPROG: if (pcnt == '0) st <= S_SUSP; else pcnt <= pcnt - 1'b1;
        S_ERASE: begin
          if (wr_acc && bus_wdata == OP_SUSP) begin
            st <= S_SUSP;
          end else begin
            case (phase)
              PH_PRE: begin
                if (idx == LAST) begin
                  phase <= PH_WAIT; idx <= '0; ecnt <= CNT_W'(ERS_CYC - 1);
                end else idx <= idx + 1'b1;
              end
              PH_WAIT: begin
                if (ecnt == '0) begin phase <= PH_FILL; idx <= '0; end
                else ecnt <= ecnt - 1'b1;
              end
              default: begin
                if (idx == LAST) begin
                  st <= S_IDLE; sel <= '0; phase <= PH_PRE; idx <= '0;
                end else idx <= idx + 1'b1;
              end
            endcase
          end
        end
        S_SUSP: begin
          if (wr_acc && bus_wdata == OP_SECT && at_rest) begin
            st <= S_ERASE;
          end else if (go_prog && !hit) begin
            st <= S_SPROG; paddr <= bus_addr; pdata <= bus_wdata;
            pcnt <= CNT_W'(PROG_CYC - 1);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R12: a held answer stays put until taken
  p_rsp_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
  // R6: every status read flips bit 6
  p_tog6_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && busy) |=> (tog6 != $past(tog6)));
  // R5: unused status bits read as zero
  p_stat_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && busy) |=> ((rsp_data & STAT_ZERO_MASK) == 8'h00));
  // R4: the sector set is frozen once the erase has begun
  p_sel_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ERASE) |=> (st == S_IDLE || sel == $past(sel)));
  // R10: a suspended program always returns to suspend
  p_sprog_back_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SPROG && pcnt == '0) |=> (st == S_SUSP));
endmodule

// File: tb/tb_flash_op_ctl.sv
module tb_flash_op_ctl;
  localparam int AW = 10;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n, bus_valid, bus_we, rsp_ready;
  logic [AW-1:0] bus_addr;
  logic [7:0] bus_wdata;
  logic bus_ready, rsp_valid;
  logic [7:0] rsp_data;
  logic [7:0] model [DEPTH];
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  flash_op_ctl #(.AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data));

  function automatic int bsec(input int a);
    int sz[7] = '{2, 1, 1, 4, 8, 8, 8};
    int u = a >> (AW - 5);
    int acc = 0;
    for (int s = 0; s < 7; s++) begin
      acc += sz[s];
      if (u < acc) return s;
    end
    return 6;
  endfunction

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 13) ^ (a >> 3) ^ 8'h5A);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    bus_valid = 1'b1; bus_we = 1'b1; bus_addr = AW'(a); bus_wdata = 8'(d);
    @(negedge clk);
    bus_valid = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] q);
    bus_valid = 1'b1; bus_we = 1'b0; bus_addr = AW'(a);
    @(negedge clk);
    bus_valid = 1'b0;
    q = rsp_data;
  endtask

  task automatic unlock();
    wr('h55, 'hAA); wr('hAA, 'h55);
  endtask

  task automatic prog(input int a, input int d);
    unlock(); wr('h55, 'hA0); wr(a, d);
  endtask

  task automatic setup_ers();
    unlock(); wr('h55, 'h80); unlock();
  endtask

  task automatic poll(input int a, output logic [7:0] last);
    logic [7:0] q0, q1;
    int n = 0;
    rd(a, q0);
    forever begin
      rd(a, q1); n++;
      if (q0[6] == q1[6] || n > 6000) break;
      q0 = q1;
    end
    last = q1;
    chk(n <= 6000, "R6 poll ends", n, 6000);
  endtask

  task automatic sweep(input string req);
    logic [7:0] q;
    for (int a = 0; a < DEPTH; a++) begin
      rd(a, q);
      chk(q == model[a], req, q, model[a]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] q, q2, q3, q4;
    rst_n = 1'b0; bus_valid = 1'b0; bus_we = 1'b0; bus_addr = '0;
    bus_wdata = '0; rsp_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(bus_ready == 1'b1, "R12 reset ready", bus_ready, 1);
    chk(rsp_valid == 1'b0, "R12 reset rsp_valid", rsp_valid, 0);

    // chip erase
    setup_ers(); wr('h55, 'h10);
    rd(0, q); rd(0, q2);
    chk(q[6] != q2[6], "R6 chip toggle", q2[6], !q[6]);
    chk(q[2] != q2[2], "R7 chip all selected", q2[2], !q[2]);
    chk(q[7] == 1'b0, "R8 erase dq7", q[7], 0);
    poll(0, q);
    for (int a = 0; a < DEPTH; a++) model[a] = 8'hFF;
    sweep("R4 chip erase");

    // program every byte
    for (int a = 0; a < DEPTH; a++) begin
      prog(a, pat(a));
      rd(a, q);
      chk(q[7] == ~pat(a)[7], "R8 prog dq7", q[7], ~pat(a)[7]);
      chk((q & 8'h3B) == 8'h00, "R5 zero bits", q, 0);
      poll(a, q);
      model[a] = model[a] & pat(a);
      chk(q == model[a], "R3 prog data", q, model[a]);
    end

    // only clears bits
    prog(5, 'h3C); poll(5, q);
    model[5] = model[5] & 8'h3C;
    chk(q == model[5], "R3 bit clear", q, model[5]);

    // broken sequence and clear value
    wr('h55, 'hAA); wr('hAA, 'h77); wr('h55, 'hA0); wr(9, 'h00);
    rd(9, q); rd(9, q2);
    chk(q == model[9] && q2 == model[9], "R2 out of sequence", q2, model[9]);
    unlock(); wr(0, 'hF0); wr('h55, 'hA0); wr(11, 'h00);
    rd(11, q);
    chk(q == model[11], "R2 clear command", q, model[11]);

    // sector erase of sectors 1 and 4
    setup_ers(); wr(64, 'h30); wr(256, 'h30);
    rd(64, q); rd(64, q2); rd(0, q3); rd(0, q4);
    chk(q[2] != q2[2], "R7 selected toggles", q2[2], !q[2]);
    chk(q3[2] == q4[2], "R7 unselected holds", q4[2], q3[2]);
    chk(q2[6] != q3[6] && q3[6] != q4[6], "R6 every read", q4[6], !q3[6]);
    poll(0, q);
    for (int a = 0; a < DEPTH; a++) if (bsec(a) == 1 || bsec(a) == 4) model[a] = 8'hFF;
    sweep("R1 R4 sector erase");

    // suspend inside erase of sector 3
    setup_ers(); wr(130, 'h30);
    repeat (20) @(negedge clk);
    wr(0, 'hB0);
    rd(100, q);
    chk(q == model[100], "R9 read unselected", q, model[100]);
    rd(130, q); rd(130, q2);
    chk(q[6] != q2[6] && q[2] != q2[2], "R9 status on erasing", q2, q);
    prog(100, 'h0F); poll(100, q);
    model[100] = model[100] & 8'h0F;
    chk(q == model[100], "R10 prog in suspend", q, model[100]);
    prog(200, 'h00);
    rd(100, q); rd(100, q2);
    chk(q == model[100] && q2 == model[100], "R10 erasing prog ignored", q2, model[100]);
    wr(0, 'h30);
    poll(0, q);
    for (int a = 0; a < DEPTH; a++) if (bsec(a) == 3) model[a] = 8'hFF;
    sweep("R9 resume completes");

    // reset aborts a program
    prog(300, 'h00);
    repeat (2) @(negedge clk);
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
    rd(300, q); rd(300, q2);
    chk(q == 8'hFF && q2 == 8'hFF, "R11 abort", q2, 8'hFF);
    prog(300, 'h5A); poll(300, q);
    chk(q == 8'h5A, "R11 new command", q, 8'h5A);
    model[300] = 8'h5A;

    // back-pressure on read answer
    rsp_ready = 1'b0;
    bus_valid = 1'b1; bus_we = 1'b0; bus_addr = AW'(300);
    @(negedge clk);
    bus_addr = AW'(100);
    chk(rsp_valid && !bus_ready && rsp_data == model[300], "R12 stall", rsp_data, model[300]);
    @(negedge clk);
    chk(!bus_ready && rsp_data == model[300], "R12 hold", rsp_data, model[300]);
    rsp_ready = 1'b1;
    @(negedge clk);
    bus_valid = 1'b0;
    chk(rsp_valid && rsp_data == model[100], "R12 release", rsp_data, model[100]);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule